// File: doc/BRIEF.md
# Optical-Disc Sector Frame Formatter

This block turns one 2048-byte user-data sector into the byte stream a host expects for one optical-disc sector. In cooked mode the user bytes pass straight through. In raw mode the block wraps them in a full 2352-byte frame: a sync field first, then a four-byte address header with minute, second and frame values derived from the sector address, then the user data, and last a zero-filled correction area. The correction area carries no computed code.

A start pulse captures the sector address and the mode. The block then presents the storage block address (four 512-byte blocks per sector) and pulls the user data from an upstream valid/ready stream. It emits the result on a downstream valid/ready stream that marks the final byte. The minute/second/frame values come from two serial dividers that run while the sync field goes out. Downstream output waits at the header until both dividers have finished.

Top module: `sfmt_sector_fmt`

## Requirements
- R1: After reset, outValid, inReady, outLast and errPulse are all low.
- R2: With mode 2'b01 (cooked) a start yields exactly DATA_LEN bytes, each equal to the upstream byte of the same index, and nothing else.
- R3: With mode 2'b10 (raw) a start yields exactly 12 + 4 + DATA_LEN + PAD_LEN bytes (2352 by default): sync at indices 0..11, header at 12..15, user data from index 16, padding after the data.
- R4: The raw sync field is 0x00 at index 0 followed by 0xFF at indices 1 through 11.
- R5: With a = address + 150, raw header byte 12 is the minute a/75/60, byte 13 the second (a/75) mod 60, byte 14 the frame a mod 75, and byte 15 the constant 0x01.
- R6: Every raw byte after the user data is 0x00.
- R7: outLast is high on the final byte of a frame and on no other byte.
- R8: A byte held with outValid high and outReady low stays unchanged; user data moves only when both inValid and outReady are high, and exactly DATA_LEN upstream bytes are consumed per frame.
- R9: Raw header bytes are not offered until the address conversion has finished; outValid stays low at the header in the meantime.
- R10: blkAddr equals four times the address captured by the accepted start and holds until the next accepted start.
- R11: A start with mode 2'b00 or 2'b11 raises errPulse for exactly one cycle, in the cycle after the start, and produces no output.
- R12: A start while a frame is in progress is ignored: no errPulse, no change to blkAddr, and the frame in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one sector frame |
| mode | input | 2 | 2'b01 cooked, 2'b10 raw, other values are rejected |
| lba | input | ADDR_W | Sector address captured at start |
| blkAddr | output | ADDR_W+2 | First 512-byte storage block of the sector |
| inData | input | 8 | Upstream user-data byte |
| inValid | input | 1 | Upstream byte available |
| inReady | output | 1 | Upstream byte taken this cycle when inValid is high |
| outData | output | 8 | Formatted output byte |
| outValid | output | 1 | outData is valid |
| outReady | input | 1 | Downstream accepts the byte |
| outLast | output | 1 | Marks the final byte of a frame |
| errPulse | output | 1 | One-cycle pulse for a rejected mode |

## Verification
The bench builds the block with its default parameters: a 20-bit address, 2048 data bytes and 288 pad bytes. Every frame therefore has the real 2352-byte layout, and the largest address pushes the minute value to 233. The table of vectors covers the address where the frame count reaches 74, the point where it wraps to a new minute, address zero, and the largest address. Both modes run, with the upstream and downstream streams either free-running or throttled in patterns that do not line up. With the default address width the two dividers take more cycles than the 12 sync bytes, so the header stall is exercised and measured. Other checks cover rejected modes and starts issued in the middle of a frame.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  localparam int SYNC_LEN    = 12;
  localparam int HDR_LEN     = 4;
  localparam int LBA_BIAS    = 150;
  localparam int FRAME_DIV   = 75;
  localparam int SEC_DIV     = 60;
  localparam logic [7:0] HDR_MODE_BYTE = 8'h01;

  typedef enum logic [1:0] {
    MODE_BAD0   = 2'b00,
    MODE_COOKED = 2'b01,
    MODE_RAW    = 2'b10,
    MODE_BAD3   = 2'b11
  } fmt_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture address, start conversion, set start position
    logic raw;     // frame kind for load
    logic active;  // frame in progress
    logic step;    // a byte leaves this cycle
  } dp_ctl_t;
endpackage

// File: rtl/sfmt_serdiv.sv
module sfmt_serdiv #(
  parameter int W = 21,
  parameter int D = 75,
  localparam int RW = $clog2(D) + 1,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          go,
  input  logic [W-1:0]  dividend,
  output logic          done,
  output logic [W-1:0]  quo,
  output logic [RW-1:0] rem
);
  logic [CW-1:0] cnt;
  logic [RW:0]   trial;

  always_comb trial = {rem, quo[W-1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      quo  <= '0;
      rem  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem <= '0;
        quo <= dividend;
        cnt <= CW'(W);
      end else if (cnt != '0) begin
        if (trial >= (RW+1)'(D)) begin
          rem <= RW'(trial - (RW+1)'(D));
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= trial[RW-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end

  // R5: a finished remainder is always below the divisor
  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rem < RW'(D)));
endmodule

// File: rtl/sfmt_datapath.sv
module sfmt_datapath
  import sfmt_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_LEN = 2048,
  parameter int PAD_LEN  = 288
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [ADDR_W-1:0] lba,
  output logic [ADDR_W+1:0] blkAddr,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [7:0]        outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outLast
);
  localparam int DATA_START  = SYNC_LEN + HDR_LEN;
  localparam int PAD_START   = DATA_START + DATA_LEN;
  localparam int RAW_LAST    = PAD_START + PAD_LEN - 1;
  localparam int COOKED_LAST = PAD_START - 1;
  localparam int POS_W       = $clog2(RAW_LAST + 1);
  localparam int DW          = ADDR_W + 1;
  localparam int FRW         = $clog2(FRAME_DIV) + 1;
  localparam int SRW         = $clog2(SEC_DIV) + 1;

  logic [POS_W-1:0]  pos;
  logic              rawR, msfReady;
  logic [ADDR_W-1:0] lbaR;
  logic [DW-1:0]     totSec, minutes;
  logic [FRW-1:0]    frames;
  logic [SRW-1:0]    seconds;
  logic              div1Done, div2Done;
  logic              inSync, inHdr, inDataReg;
  logic [POS_W-1:0]  lastPos;

  sfmt_serdiv #(.W(DW), .D(FRAME_DIV)) u_divFrame (
    .clk(clk), .rstN(rstN), .go(ctl.load),
    .dividend(DW'(lba) + DW'(LBA_BIAS)),
    .done(div1Done), .quo(totSec), .rem(frames));

  sfmt_serdiv #(.W(DW), .D(SEC_DIV)) u_divSec (
    .clk(clk), .rstN(rstN), .go(div1Done),
    .dividend(totSec),
    .done(div2Done), .quo(minutes), .rem(seconds));

  always_comb begin
    inSync    = pos < POS_W'(SYNC_LEN);
    inHdr     = !inSync && (pos < POS_W'(DATA_START));
    inDataReg = (pos >= POS_W'(DATA_START)) && (pos < POS_W'(PAD_START));
    lastPos   = rawR ? POS_W'(RAW_LAST) : POS_W'(COOKED_LAST);
    if (!ctl.active)    outValid = 1'b0;
    else if (inDataReg) outValid = inValid;
    else if (inHdr)     outValid = msfReady;
    else                outValid = 1'b1;
    inReady = ctl.active && inDataReg && outReady;
    outLast = outValid && (pos == lastPos);
    blkAddr = {lbaR, 2'b00};
    if (inSync)         outData = (pos == '0) ? 8'h00 : 8'hFF;
    else if (inHdr) begin
      case (pos[1:0])
        2'd0:    outData = minutes[7:0];
        2'd1:    outData = 8'(seconds);
        2'd2:    outData = 8'(frames);
        default: outData = HDR_MODE_BYTE;
      endcase
    end
    else if (inDataReg) outData = inData;
    else                outData = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos      <= '0;
      rawR     <= 1'b0;
      msfReady <= 1'b0;
      lbaR     <= '0;
    end else begin
      if (ctl.load) begin
        pos      <= ctl.raw ? '0 : POS_W'(DATA_START);
        rawR     <= ctl.raw;
        lbaR     <= lba;
        msfReady <= 1'b0;
      end else begin
        if (ctl.step) pos <= pos + 1'b1;
        if (div2Done) msfReady <= 1'b1;
      end
    end
  end

  // R8: a stalled framing byte is held
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !inDataReg) |=> (outValid && $stable(outData)));
  // R7: the accepted last byte ends the frame
  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    (outLast && outReady) |=> !outValid);
  // R3: position never runs past the raw frame
  a_r3_pos_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |-> (pos <= POS_W'(RAW_LAST)));
endmodule

// File: rtl/sfmt_ctrl.sv
module sfmt_ctrl
  import sfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic       outValid,
  input  logic       outReady,
  input  logic       outLast,
  output dp_ctl_t    ctl,
  output logic       errPulse
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e  state;
  logic modeOk;

  always_comb begin
    modeOk     = (mode == 2'(MODE_COOKED)) || (mode == 2'(MODE_RAW));
    ctl.load   = (state == ST_IDLE) && start && modeOk;
    ctl.raw    = (mode == 2'(MODE_RAW));
    ctl.active = (state == ST_RUN);
    ctl.step   = ctl.active && outValid && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      errPulse <= 1'b0;
    end else begin
      errPulse <= (state == ST_IDLE) && start && !modeOk;
      if (ctl.load) state <= ST_RUN;
      else if (ctl.step && outLast) state <= ST_IDLE;
    end
  end

  // R11: a rejection never starts a frame
  a_r11_err_no_run: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (state == ST_IDLE));
  // R12: no rejection is reported while a frame runs
  a_r12_busy_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |=> !errPulse);
endmodule

// File: rtl/sfmt_sector_fmt.sv
module sfmt_sector_fmt
  import sfmt_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_LEN = 2048,
  parameter int PAD_LEN  = 288
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] lba,
  output logic [ADDR_W+1:0] blkAddr,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [7:0]        outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outLast,
  output logic              errPulse
);
  dp_ctl_t ctl;

  sfmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .outValid(outValid), .outReady(outReady), .outLast(outLast),
    .ctl(ctl), .errPulse(errPulse));

  sfmt_datapath #(.ADDR_W(ADDR_W), .DATA_LEN(DATA_LEN), .PAD_LEN(PAD_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lba(lba), .blkAddr(blkAddr),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .outLast(outLast));
endmodule

// File: tb/sim_sfmt_sector_fmt.sv
module sim_sfmt_sector_fmt;
  localparam int ADDR_W = 20;
  localparam int DLEN   = 2048;
  localparam int RAWLEN = 2352;
  localparam int NV     = 6;
  localparam logic [1:0] vMode [NV] = '{2'b10, 2'b10, 2'b10, 2'b01, 2'b10, 2'b10};
  localparam int vLba [NV] = '{0, 4349, 4350, 7, 1048575, 300001};
  localparam bit vThr [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int vMin [NV] = '{0, 0, 1, 0, 233, 66};
  localparam int vSec [NV] = '{2, 59, 0, 0, 3, 42};
  localparam int vFrm [NV] = '{0, 74, 0, 0, 0, 1};

  logic clk = 0, rstN = 0, startReq = 0;
  logic [1:0] mode = 0;
  logic [ADDR_W-1:0] lba = 0;
  logic [ADDR_W+1:0] blkAddr;
  logic [7:0] inData = 0, outData;
  logic inValid = 0, inReady, outValid, outReady = 1, outLast, errPulse;

  int checks = 0, errors = 0, cyc = 0;
  bit collecting = 0, gotLast = 0, curRaw = 0, curThr = 0, errSeen = 0, lastBad = 0;
  int curLba = 0, curMin = 0, curSec = 0, curFrm = 0;
  int beatCnt = 0, inIdx = 0, mism = 0, mIdx = 0, mAct = 0, mExp = 0;
  int syncCyc = 0, hdrCyc = 0;

  always #5 clk = ~clk;

  sfmt_sector_fmt u0 (
    .clk(clk), .rstN(rstN), .start(startReq), .mode(mode), .lba(lba),
    .blkAddr(blkAddr), .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .outLast(outLast), .errPulse(errPulse));

  function automatic logic [7:0] pat(int k, int l);
    return 8'((k * 7 + l) & 255);
  endfunction

  function automatic logic [7:0] expByte(bit raw, int idx);
    if (!raw) return pat(idx, curLba);
    if (idx == 0) return 8'h00;           // R4
    if (idx < 12) return 8'hFF;           // R4
    if (idx == 12) return 8'(curMin);     // R5
    if (idx == 13) return 8'(curSec);
    if (idx == 14) return 8'(curFrm);
    if (idx == 15) return 8'h01;
    if (idx < 16 + DLEN) return pat(idx - 16, curLba);
    return 8'h00;                          // R6
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // stream driver and observer
  always @(negedge clk) begin
    cyc++;
    if (collecting) begin
      inValid  = curThr ? ((cyc % 5) != 3) : 1'b1;
      outReady = curThr ? ((cyc % 7) != 2) : 1'b1;
      inData   = pat(inIdx, curLba);
    end else begin
      inValid  = 1'b0;
      outReady = 1'b1;
    end
    #1;
    if (collecting) begin
      if (errPulse) errSeen = 1;
      if (inValid && inReady) inIdx++;
      if (outValid && outReady && !gotLast) begin
        if (outData !== expByte(curRaw, beatCnt)) begin
          if (mism == 0) begin mIdx = beatCnt; mAct = outData; mExp = expByte(curRaw, beatCnt); end
          mism++;
        end
        if (beatCnt == 11) syncCyc = cyc;
        if (beatCnt == 12) hdrCyc = cyc;
        if (outLast) begin
          gotLast = 1;
          if (beatCnt != (curRaw ? RAWLEN : DLEN) - 1) lastBad = 1;
        end
        beatCnt++;
      end
    end
  end

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
    finishRun();
  end

  task automatic runVector(int v);
    @(negedge clk);
    beatCnt = 0; inIdx = 0; mism = 0; gotLast = 0; errSeen = 0; lastBad = 0;
    curRaw = (vMode[v] == 2'b10); curThr = vThr[v]; curLba = vLba[v];
    curMin = vMin[v]; curSec = vSec[v]; curFrm = vFrm[v];
    @(negedge clk);
    mode = vMode[v]; lba = ADDR_W'(vLba[v]); startReq = 1; collecting = 1;
    @(negedge clk);
    startReq = 0;
    if (v == 5) begin
      // R12: starts issued mid-frame, one valid and one rejected mode
      wait (beatCnt >= 100);
      @(negedge clk); mode = 2'b01; lba = 5; startReq = 1;
      @(negedge clk); startReq = 0;
      @(negedge clk); mode = 2'b11; startReq = 1;
      @(negedge clk); startReq = 0; mode = vMode[v];
    end
    wait (gotLast);
    @(negedge clk); @(negedge clk);
    collecting = 0;
    // R2 / R3: frame length
    check(beatCnt == (curRaw ? RAWLEN : DLEN), curRaw ? "R3 length" : "R2 length",
          beatCnt, curRaw ? RAWLEN : DLEN);
    // R2..R6: content, including sync, header and padding
    if (mism != 0) $display("  first mismatch at byte %0d: %0d vs %0d", mIdx, mAct, mExp);
    check(mism == 0, curRaw ? "R4 R5 R6 content" : "R2 content", mism, 0);
    check(!lastBad, "R7 last marker", lastBad, 0);
    check(inIdx == DLEN, "R8 upstream bytes", inIdx, DLEN);
    check(blkAddr == (ADDR_W+2)'(vLba[v] * 4), "R10 block address", blkAddr, vLba[v] * 4);
    check(!errSeen, (v == 5) ? "R12 no error mid-frame" : "R11 no error on good mode", errSeen, 0);
    if (v == 0) check(hdrCyc - syncCyc > 1, "R9 header stall", hdrCyc - syncCyc, 2);
  endtask

  task automatic badMode(logic [1:0] m);
    int seen = 0;
    @(negedge clk); mode = m; lba = 9; startReq = 1;
    @(negedge clk); startReq = 0;
    check(errPulse == 1'b1, "R11 error pulse", errPulse, 1);
    @(negedge clk);
    check(errPulse == 1'b0, "R11 single-cycle pulse", errPulse, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #2;
      if (outValid || inReady) seen++;
    end
    check(seen == 0, "R11 no output", seen, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    check(!outValid && !inReady && !outLast && !errPulse, "R1 reset outputs",
          {outValid, inReady, outLast, errPulse}, 0);
    @(negedge clk); rstN = 1;
    @(negedge clk); #2;
    check(!outValid && !errPulse, "R1 idle after reset", {outValid, errPulse}, 0);
    for (int v = 0; v < NV; v++) runVector(v);
    badMode(2'b00);
    badMode(2'b11);
    runVector(3);  // R2: a good frame still follows the rejections
    finishRun();
  end
endmodule